// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global record of the outcomes of the most recent branches, taken from every branch in the program. It also keeps a table of 2-bit saturating counters, organised in rows. The row comes from low-order bits of the branch address. The global record then picks one counter within that row. The guess is the upper bit of that counter.

Entries carry no address tag. Two branches whose index bits match share the same counters, and this aliasing is accepted by design. When the number of history bits is set to zero, the block becomes a plain table of per-address 2-bit counters.

The fetch stage drives an address on the predict side and reads the guess back in the same cycle, through combinational logic. The resolve stage reports each finished branch on the update side as a valid strobe, the branch address and the real outcome. The update side has no back-pressure: it accepts one branch on every cycle in which the strobe is high. The only two data paths are this single-cycle lookup and a write that happens on every strobe, so both sides stay as plain pins and have no ready signal.

Top module: `corr_branch_predictor`

## Requirements
- R1: After a synchronous reset, every counter holds 01 (weak not-taken) and the history is all zeros. In this state the prediction is 0 for every address.
- R2: The prediction is bit 1 of one counter. Its row is pc[ROW_BITS+1:2] and its column is the current history value. The table entry is row*2^HIST_BITS + history, and counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken.
- R3: A valid update with outcome taken increments the selected counter, which saturates at 11.
- R4: A valid update with outcome not-taken decrements the selected counter, which saturates at 00.
- R5: A counter in a strong state keeps predicting the same direction after one opposite outcome. Its direction flips only after a second consecutive opposite outcome.
- R6: An update writes only the counter picked by the update address and the history in force at that edge. Counters in other columns of the same row and in other rows are left unchanged.
- R7: On each valid update the history shifts left by one and takes the outcome (1 = taken) into its least significant bit. While the strobe is low, the history and the counters stay unchanged.
- R8: No address tag is checked, so addresses that differ only above bit ROW_BITS+1 share counters and give the same prediction.
- R9: Address bits [1:0] are ignored by both the predict side and the update side.
- R10: A lookup in the same cycle as an update sees the state from before the update. The new state becomes visible after the clock edge.
- R11: With HIST_BITS = 0, the predictor acts as one 2-bit counter per row, and the outcome history has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Guess: 1 = taken |
| upd_valid | input | 1 | Strobe that reports one resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome: 1 = taken |

## Verification
The properties take for granted that reset is asserted from time zero and that upd_taken has a known value whenever upd_valid is high. The bench keeps to this by driving inputs only on the falling edge, holding reset for several cycles at the start and driving the outcome together with each strobe. The history and counter checks rely on updates arriving one per cycle with no back-pressure, and the stimulus issues at most one update per edge.

// File: rtl/gpred_pkg.sv
package gpred_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // Saturating step of a 2-bit direction counter.
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
    else       res = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return res;
  endfunction
endpackage

// File: rtl/gpred_hist.sv
module gpred_hist #(
  parameter int HIST_BITS = 2,
  localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HW-1:0] hist_o
);
  generate
    if (HIST_BITS == 0) begin : g_none
      logic unused_hist;
      assign unused_hist = ^{clk, rst, shift_en, bit_in};
      assign hist_o = '0;
    end else if (HIST_BITS == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist_o <= '0;
        else if (shift_en) hist_o <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_o <= '0;
        else if (shift_en) hist_o <= {hist_o[HW-2:0], bit_in};
      end
    end
  endgenerate
endmodule

// File: rtl/gpred_index.sv
module gpred_index #(
  parameter int PC_W      = 32,
  parameter int ROW_BITS  = 4,
  parameter int HIST_BITS = 2,
  localparam int HW    = (HIST_BITS > 0) ? HIST_BITS : 1,
  localparam int IDX_W = ROW_BITS + HIST_BITS
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [HW-1:0]    hist,
  output logic [IDX_W-1:0] idx
);
  logic [ROW_BITS-1:0] row;
  logic unused_pc;

  // word-aligned: bits [1:0] carry nothing; upper bits are not tagged
  assign row       = pc[ROW_BITS+1:2];
  assign unused_pc = ^{pc[PC_W-1:ROW_BITS+2], pc[1:0]};

  generate
    if (HIST_BITS == 0) begin : g_flat
      logic unused_h;
      assign unused_h = ^hist;
      assign idx = row;
    end else begin : g_corr
      assign idx = {row, hist};
    end
  endgenerate
endmodule

// File: rtl/gpred_table.sv
module gpred_table
  import gpred_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output ctr_t             wr_old,
  output ctr_t             wr_new
);
  ctr_t ctr_q [ENTRIES];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_next(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import gpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ROW_BITS  = 4,
  parameter int HIST_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int HW    = (HIST_BITS > 0) ? HIST_BITS : 1;
  localparam int IDX_W = ROW_BITS + HIST_BITS;

  logic [HW-1:0]    ghist;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  ctr_t             rd_ctr;
  ctr_t             wr_old;
  ctr_t             wr_new;

  gpred_hist #(.HIST_BITS(HIST_BITS)) hist_i (
    .clk(clk), .rst(rst), .shift_en(upd_valid), .bit_in(upd_taken),
    .hist_o(ghist)
  );

  gpred_index #(.PC_W(PC_W), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) rd_ix_i (
    .pc(pred_pc), .hist(ghist), .idx(rd_idx)
  );

  gpred_index #(.PC_W(PC_W), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) wr_ix_i (
    .pc(upd_pc), .hist(ghist), .idx(wr_idx)
  );

  gpred_table #(.IDX_W(IDX_W)) tbl_i (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_ctr(rd_ctr),
    .wr_en(upd_valid), .wr_idx(wr_idx), .wr_taken(upd_taken),
    .wr_old(wr_old), .wr_new(wr_new)
  );

  assign pred_taken = rd_ctr[1];
endmodule

// File: rtl/gpred_chk.sv
module gpred_chk #(
  parameter int HIST_BITS = 2,
  parameter int HW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_valid,
  input logic          upd_taken,
  input logic [HW-1:0] ghist,
  input logic [1:0]    wr_old,
  input logic [1:0]    wr_new
);
  // R1
  hist_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ghist == '0));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghist));

  generate
    if (HIST_BITS > 0) begin : g_h
      // R7
      hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> (ghist[0] == $past(upd_taken)));
    end
  endgenerate

  // R3
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && wr_old == 2'b11) |-> (wr_new == 2'b11));

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && wr_old == 2'b00) |-> (wr_new == 2'b00));

  // R5
  hyst_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (wr_old == 2'b00 || wr_old == 2'b11)) |-> (wr_new[1] == wr_old[1]));

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (wr_new == wr_old || wr_new == wr_old + 2'd1 || wr_new == wr_old - 2'd1));
endmodule

bind corr_branch_predictor gpred_chk #(.HIST_BITS(HIST_BITS), .HW(HW)) chk_i (
  .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .ghist(ghist), .wr_old(wr_old), .wr_new(wr_new)
);

// File: tb/corr_branch_predictor_tb_top.sv
`timescale 1ns/1ps
module corr_branch_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred2, pred0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  corr_branch_predictor #(.PC_W(32), .ROW_BITS(4), .HIST_BITS(2)) dut_i (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred2),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  corr_branch_predictor #(.PC_W(32), .ROW_BITS(4), .HIST_BITS(0)) dut0_i (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred0),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // reference model from the requirements
  logic [1:0] m2 [64];
  logic [1:0] m0 [16];
  logic [1:0] mh;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  function automatic int ix2(input logic [31:0] pc);
    return int'(pc[5:2]) * 4 + int'(mh);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m2[i] = 2'b01;
    for (int i = 0; i < 16; i++) m0[i] = 2'b01;
    mh = 2'b00;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one update; lookup of the same address checked before the edge (R10)
  task automatic step(input logic [31:0] pc, input logic t, input string req);
    @(negedge clk);
    pred_pc = pc; upd_pc = pc; upd_taken = t; upd_valid = 1'b1;
    #1;
    chk({req, " R10 corr"}, pred2, m2[ix2(pc)][1]);
    chk({req, " R10 flat"}, pred0, m0[pc[5:2]][1]);
    @(posedge clk);
    m2[ix2(pc)] = sat(m2[ix2(pc)], t);
    m0[pc[5:2]] = sat(m0[pc[5:2]], t);
    mh = {mh[0], t};
    #1 upd_valid = 1'b0;
  endtask

  task automatic all_rows(input string req, input logic [31:0] hi);
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      pred_pc = hi | (32'(r) << 2);
      #1;
      chk({req, " corr"}, pred2, m2[ix2(pred_pc)][1]);
      chk({req, " flat"}, pred0, m0[r][1]);
    end
  endtask

  typedef struct packed {
    logic [31:0] pc;
    logic        t;
    logic        exp;
  } vec_t;

  // hand-derived walk on one address: expected guess before each update
  localparam vec_t VECS [10] = '{
    '{32'h10, 1'b1, 1'b0},
    '{32'h10, 1'b1, 1'b0},
    '{32'h10, 1'b1, 1'b0},
    '{32'h10, 1'b1, 1'b1},
    '{32'h10, 1'b1, 1'b1},
    '{32'h10, 1'b0, 1'b1},
    '{32'h10, 1'b0, 1'b0},
    '{32'h10, 1'b1, 1'b1},
    '{32'h10, 1'b0, 1'b1},
    '{32'h10, 1'b0, 1'b0}
  };

  initial begin : watchdog
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic a, b;
    model_reset();
    do_reset();

    // R1: all rows predict not-taken
    all_rows("R1 reset", 32'h0);

    // R2 R3 R4 R5: table walk
    foreach (VECS[i]) begin
      @(negedge clk);
      pred_pc = VECS[i].pc;
      #1;
      chk("R2 R3 R4 R5 vector", pred2, VECS[i].exp);
      step(VECS[i].pc, VECS[i].t, "R2 walk");
    end

    // R6: mixed training across rows, then whole table compare
    step(32'h00, 1'b1, "R6"); step(32'h24, 1'b0, "R6");
    step(32'h38, 1'b1, "R6"); step(32'h04, 1'b1, "R6");
    step(32'h24, 1'b1, "R6"); step(32'h38, 1'b1, "R6");
    all_rows("R6 R2 table", 32'h0);

    // R7: strobe low for several cycles must change nothing
    @(negedge clk);
    upd_valid = 1'b0; upd_taken = 1'b1; upd_pc = 32'h38;
    repeat (5) @(negedge clk);
    all_rows("R7 idle", 32'h0);

    // R8 alias and R9 low bits
    step(32'h410, 1'b1, "R8"); step(32'h410, 1'b1, "R8");
    step(32'h410, 1'b1, "R8");
    @(negedge clk);
    pred_pc = 32'h10; #1 a = pred2;
    pred_pc = 32'hABC0_0010; #1 b = pred2;
    chk("R8 alias", b, a);
    chk("R8 model", a, m2[ix2(32'h10)][1]);
    pred_pc = 32'h13; #1;
    chk("R9 low bits", pred2, a);
    step(32'h13, 1'b0, "R9");
    all_rows("R9 R8 table", 32'h7700_0000);

    // R11: flat variant ignores history
    do_reset();
    step(32'h08, 1'b1, "R11"); step(32'h08, 1'b1, "R11");
    @(negedge clk);
    pred_pc = 32'h08; #1;
    chk("R11 flat taken", pred0, 1'b1);
    chk("R11 corr new column", pred2, 1'b0);

    // R1: reset after training
    step(32'h30, 1'b1, "R1"); step(32'h30, 1'b1, "R1");
    do_reset();
    all_rows("R1 re-reset", 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule